// File: doc/BRIEF.md
# Byte-Lane Bank Select Decoder

This block sits between a 16-bit host data bus and a byte-addressable memory of 2^20 bytes. The memory is built as two 8-bit banks of 2^19 bytes each. One holds the even byte addresses and the other holds the odd byte addresses. Each bank receives the same word address, which is the host address with bit 0 removed. Each bank has its own chip select and write enable.

The two banks are selected by two signals together: host address bit 0 and an active-low high-byte enable. Address bit 0 low selects the even bank, and the enable low selects the odd bank. This gives three kinds of transfer:
- a full 16-bit word, with both banks selected;
- a lower-byte transfer, with the even bank alone;
- an upper-byte transfer, with the odd bank alone.

The even bank always uses data bits 7..0 and the odd bank always uses bits 15..8. Bytes are never moved between lanes.

On writes, the block routes the host lanes to the banks. On reads, it merges the bank outputs into a 16-bit word. Any lane whose bank was not selected reads as zero. The merged word is registered at the clock edge that ends the read cycle. The RAM arrays and the bus timing are outside this block.

Top module: `lane_bank_decoder`

## Requirements
- R1: `bank_addr_o` always equals host address bits 19..1 in the same cycle.
- R2: An access takes place only when exactly one of `rd_i` and `wr_i` is high. With neither or both high, all chip selects and write enables are low and `rdata_o` keeps its value.
- R3: With address bit 0 = 0 and `hi_en_n_i` = 0, both `even_cs_o` and `odd_cs_o` are high in the same cycle.
- R4: With address bit 0 = 0 and `hi_en_n_i` = 1, only `even_cs_o` is high.
- R5: With address bit 0 = 1 and `hi_en_n_i` = 0, only `odd_cs_o` is high. The byte travels on data bits 15..8 in both directions.
- R6: With address bit 0 = 1 and `hi_en_n_i` = 1, no bank is selected, nothing is written, and `rdata_o` keeps its value.
- R7: During a write access:
  - each selected bank's write enable is high;
  - `even_wdata_o` carries `wdata_i[7:0]` and `odd_wdata_o` carries `wdata_i[15:8]`.
  
  In every other cycle, both write enables and both bank write-data outputs are zero.
- R8: At the clock edge that ends a read access, `rdata_o` captures `{odd lane, even lane}`. A lane whose bank was not selected is zero. The value is visible after that edge and changes at no other edge.
- R9: While `rst_n` is low, `rdata_o` is zero. Reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Host byte address |
| hi_en_n_i | input | 1 | Active-low enable for the upper byte lane |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Registered merged read data |
| bank_addr_o | output | 19 | Word address shared by both banks |
| even_cs_o | output | 1 | Even bank chip select |
| odd_cs_o | output | 1 | Odd bank chip select |
| even_we_o | output | 1 | Even bank write enable |
| odd_we_o | output | 1 | Odd bank write enable |
| even_wdata_o | output | 8 | Write byte to the even bank |
| odd_wdata_o | output | 8 | Write byte to the odd bank |
| even_rdata_i | input | 8 | Read byte from the even bank |
| odd_rdata_i | input | 8 | Read byte from the odd bank |

## Verification
The results fall into two timing groups.
- **Same cycle as the stimulus.** The bank address, chip selects, write enables and bank write bytes are purely combinational. The bench drives each vector on a falling clock edge and checks these outputs 2 ns later, before the next rising edge.
- **One rising edge later.** Read data crosses a single register. The bench checks `rdata_o` 1 ns after the rising edge that closes the access. At that same point it confirms that ignored, idle and conflicting cycles left the previous value in place.

Reset is checked both while held and when asserted between edges.

// File: rtl/lane_bank_pkg.sv
package lane_bank_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_LOW  = 2'd1,
      ACC_HIGH = 2'd2,
      ACC_WORD = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic lo_sel;
      logic hi_sel;
      logic is_wr;
      logic is_rd;
   } lane_sel_t;

   // Pair of address LSB and active-low upper enable -> transfer kind
   function automatic acc_kind_e classify(input logic a_lsb, input logic hi_en_n);
      acc_kind_e k;
      unique case ({a_lsb, hi_en_n})
         2'b00:   k = ACC_WORD;
         2'b01:   k = ACC_LOW;
         2'b10:   k = ACC_HIGH;
         default: k = ACC_IDLE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/lane_select.sv
module lane_select
   import lane_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      a_lsb_i,
   input  logic      hi_en_n_i,
   input  logic      rd_i,
   input  logic      wr_i,
   output lane_sel_t sel_o
);

   logic      strobe;
   acc_kind_e kind;

   // exactly one strobe makes a live cycle
   assign strobe = rd_i ^ wr_i;

   always_comb begin
      kind = ACC_IDLE;
      if (strobe) kind = classify(a_lsb_i, hi_en_n_i);
   end

   always_comb begin
      sel_o        = '0;
      sel_o.is_wr  = strobe & wr_i;
      sel_o.is_rd  = strobe & rd_i;
      unique case (kind)
         ACC_WORD: begin sel_o.lo_sel = 1'b1; sel_o.hi_sel = 1'b1; end
         ACC_LOW:  sel_o.lo_sel = 1'b1;
         ACC_HIGH: sel_o.hi_sel = 1'b1;
         default:  ;
      endcase
   end

   // R5
   high_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && a_lsb_i && !hi_en_n_i) |-> (sel_o.hi_sel && !sel_o.lo_sel));

   // R2
   conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && wr_i) |-> (!sel_o.lo_sel && !sel_o.hi_sel && !sel_o.is_wr));

endmodule

// File: rtl/lane_steer.sv
module lane_steer
   import lane_bank_pkg::*;
#(
   parameter int BYTE_W = 8
)(
   input  lane_sel_t                sel_i,
   input  logic [2*BYTE_W-1:0]      wdata_i,
   input  logic [BYTE_W-1:0]        even_rdata_i,
   input  logic [BYTE_W-1:0]        odd_rdata_i,
   output logic                     even_cs_o,
   output logic                     odd_cs_o,
   output logic                     even_we_o,
   output logic                     odd_we_o,
   output logic [BYTE_W-1:0]        even_wdata_o,
   output logic [BYTE_W-1:0]        odd_wdata_o,
   output logic [2*BYTE_W-1:0]      merged_o
);

   localparam int LANES = 2;

   logic              lane_sel [LANES];
   logic              lane_we  [LANES];
   logic [BYTE_W-1:0] lane_rd  [LANES];
   logic [BYTE_W-1:0] lane_wd  [LANES];

   assign lane_sel[0] = sel_i.lo_sel;
   assign lane_sel[1] = sel_i.hi_sel;
   assign lane_rd[0]  = even_rdata_i;
   assign lane_rd[1]  = odd_rdata_i;

   // lane g of the host bus always maps to bank g; no byte swapping
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = lane_sel[g] & sel_i.is_wr;
      assign lane_wd[g] = lane_we[g] ? wdata_i[g*BYTE_W +: BYTE_W] : '0;
      assign merged_o[g*BYTE_W +: BYTE_W] =
         (lane_sel[g] & sel_i.is_rd) ? lane_rd[g] : '0;
   end

   assign even_cs_o    = lane_sel[0];
   assign odd_cs_o     = lane_sel[1];
   assign even_we_o    = lane_we[0];
   assign odd_we_o     = lane_we[1];
   assign even_wdata_o = lane_wd[0];
   assign odd_wdata_o  = lane_wd[1];

endmodule

// File: rtl/rd_capture.sv
module rd_capture #(
   parameter int W      = 16,
   parameter bit RD_REG = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);

   if (RD_REG) begin : g_reg
      logic [W-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hold_q <= '0;
         else if (fire_i) hold_q <= din_i;
      end

      assign dout_o = hold_q;

      // R8
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !fire_i |=> $stable(dout_o));
   end else begin : g_pass
      assign dout_o = fire_i ? din_i : '0;
   end

endmodule

// File: rtl/lane_bank_decoder.sv
module lane_bank_decoder
   import lane_bank_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BYTE_W = 8,
   parameter bit RD_REG = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     hi_en_n_i,
   input  logic                     rd_i,
   input  logic                     wr_i,
   input  logic [2*BYTE_W-1:0]      wdata_i,
   output logic [2*BYTE_W-1:0]      rdata_o,
   output logic [ADDR_W-2:0]        bank_addr_o,
   output logic                     even_cs_o,
   output logic                     odd_cs_o,
   output logic                     even_we_o,
   output logic                     odd_we_o,
   output logic [BYTE_W-1:0]        even_wdata_o,
   output logic [BYTE_W-1:0]        odd_wdata_o,
   input  logic [BYTE_W-1:0]        even_rdata_i,
   input  logic [BYTE_W-1:0]        odd_rdata_i
);

   localparam int DATA_W  = 2 * BYTE_W;
   localparam int BANK_AW = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_aw
      $error("lane_bank_decoder: ADDR_W must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_bw
      $error("lane_bank_decoder: BYTE_W must be at least 1");
   end

   lane_sel_t           sel;
   logic [DATA_W-1:0]   merged;
   logic                rd_fire;

   assign bank_addr_o = addr_i[ADDR_W-1:1];

   lane_select u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .a_lsb_i   (addr_i[0]),
      .hi_en_n_i (hi_en_n_i),
      .rd_i      (rd_i),
      .wr_i      (wr_i),
      .sel_o     (sel)
   );

   lane_steer #(.BYTE_W(BYTE_W)) u_steer (
      .sel_i        (sel),
      .wdata_i      (wdata_i),
      .even_rdata_i (even_rdata_i),
      .odd_rdata_i  (odd_rdata_i),
      .even_cs_o    (even_cs_o),
      .odd_cs_o     (odd_cs_o),
      .even_we_o    (even_we_o),
      .odd_we_o     (odd_we_o),
      .even_wdata_o (even_wdata_o),
      .odd_wdata_o  (odd_wdata_o),
      .merged_o     (merged)
   );

   assign rd_fire = sel.is_rd & (sel.lo_sel | sel.hi_sel);

   rd_capture #(.W(DATA_W), .RD_REG(RD_REG)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (rd_fire),
      .din_i  (merged),
      .dout_o (rdata_o)
   );

   // R7
   even_we_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      even_we_o |-> (even_cs_o && wr_i && !rd_i));

   // R7
   odd_we_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      odd_we_o |-> (odd_cs_o && wr_i && !rd_i));

   // R3
   word_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_i ^ wr_i) && !addr_i[0] && !hi_en_n_i) |-> (even_cs_o && odd_cs_o));

   // R6
   none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i[0] && hi_en_n_i) |-> (!even_cs_o && !odd_cs_o && !even_we_o && !odd_we_o));

   if (RD_REG) begin : g_rd_chk
      // R8
      lo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_fire && !even_cs_o) |=> (rdata_o[BYTE_W-1:0] == '0));
      // R8
      hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_fire && !odd_cs_o) |=> (rdata_o[DATA_W-1:BYTE_W] == '0));
   end

endmodule

// File: tb/sim_lane_bank_decoder.sv
module sim_lane_bank_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] addr = '0;
   logic        hen = 1'b1;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [18:0] bank_addr;
   logic        ecs, ocs, ewe, owe;
   logic [7:0]  ewd, owd, erd, ord;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   lane_bank_decoder u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_i       (addr),
      .hi_en_n_i    (hen),
      .rd_i         (rd),
      .wr_i         (wr),
      .wdata_i      (wdata),
      .rdata_o      (rdata),
      .bank_addr_o  (bank_addr),
      .even_cs_o    (ecs),
      .odd_cs_o     (ocs),
      .even_we_o    (ewe),
      .odd_we_o     (owe),
      .even_wdata_o (ewd),
      .odd_wdata_o  (owd),
      .even_rdata_i (erd),
      .odd_rdata_i  (ord)
   );

   // behavioural bank RAMs, 256 entries each, indexed by word address bits 7..0
   logic [7:0] even_mem [256];
   logic [7:0] odd_mem  [256];
   logic [7:0] sh_even  [256];
   logic [7:0] sh_odd   [256];

   assign erd = even_mem[bank_addr[7:0]];
   assign ord = odd_mem[bank_addr[7:0]];

   always @(posedge clk) begin
      if (ewe) even_mem[bank_addr[7:0]] <= ewd;
      if (owe) odd_mem[bank_addr[7:0]]  <= owd;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // {op[1:0] (01 write, 10 read, 11 both, 00 none), hi_en_n, addr[19:0], wdata[15:0], exp_cs {odd,even}}
   localparam int NV = 15;
   localparam logic [40:0] VEC [NV] = '{
      {2'b01, 1'b0, 20'h00010, 16'hBEEF, 2'b11},
      {2'b10, 1'b0, 20'h00010, 16'h0000, 2'b11},
      {2'b01, 1'b1, 20'h00020, 16'h1234, 2'b01},
      {2'b10, 1'b0, 20'h00020, 16'h0000, 2'b11},
      {2'b01, 1'b0, 20'h00031, 16'hAB00, 2'b10},
      {2'b10, 1'b0, 20'h00031, 16'h0000, 2'b10},
      {2'b10, 1'b1, 20'h00030, 16'h0000, 2'b01},
      {2'b01, 1'b1, 20'h00041, 16'hFFFF, 2'b00},
      {2'b10, 1'b1, 20'h00041, 16'h0000, 2'b00},
      {2'b11, 1'b0, 20'h00040, 16'hC3C3, 2'b00},
      {2'b00, 1'b0, 20'h00040, 16'h7777, 2'b00},
      {2'b10, 1'b0, 20'h00040, 16'h0000, 2'b11},
      {2'b01, 1'b0, 20'hFFFFE, 16'h5AA5, 2'b11},
      {2'b10, 1'b0, 20'hFFFFE, 16'h0000, 2'b11},
      {2'b00, 1'b1, 20'h00001, 16'h0000, 2'b00}
   };

   initial begin
      logic [15:0] exp_rd;
      exp_rd = '0;
      for (int i = 0; i < 256; i++) begin
         even_mem[i] = 8'(i) ^ 8'h5A;
         odd_mem[i]  = 8'(i) ^ 8'hA5;
         sh_even[i]  = 8'(i) ^ 8'h5A;
         sh_odd[i]   = 8'(i) ^ 8'hA5;
      end

      // R9: reset holds read data at zero
      repeat (3) @(posedge clk);
      #1 check("R9 reset value", 32'(rdata), 32'h0);
      @(negedge clk) rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [1:0]  op;
         logic [1:0]  ecsv;
         logic [7:0]  idx;
         string       tag;
         op    = VEC[v][40:39];
         ecsv  = VEC[v][1:0];
         @(negedge clk);
         hen   = VEC[v][38];
         addr  = VEC[v][37:18];
         wdata = VEC[v][17:2];
         rd    = op[1];
         wr    = op[0];
         idx   = addr[8:1];
         tag   = (ecsv == 2'b11) ? "R3" : (ecsv == 2'b01) ? "R4" :
                 (ecsv == 2'b10) ? "R5" : (op == 2'b01 || op == 2'b10) ? "R6" : "R2";
         #2;
         check("R1 bank address", 32'(bank_addr), 32'(addr[19:1]));
         check({tag, " chip selects"}, 32'({ocs, ecs}), 32'(ecsv));
         check("R7 write enables", 32'({owe, ewe}), (op == 2'b01) ? 32'(ecsv) : 32'h0);
         if (op == 2'b01) begin
            check("R7 even write lane", 32'(ewd), ecsv[0] ? 32'(wdata[7:0]) : 32'h0);
            check("R7 odd write lane",  32'(owd), ecsv[1] ? 32'(wdata[15:8]) : 32'h0);
            if (ecsv[0]) sh_even[idx] = wdata[7:0];
            if (ecsv[1]) sh_odd[idx]  = wdata[15:8];
         end else begin
            check("R7 idle write lanes", 32'({owd, ewd}), 32'h0);
         end
         if (op == 2'b10 && ecsv != 2'b00)
            exp_rd = {ecsv[1] ? sh_odd[idx] : 8'h00, ecsv[0] ? sh_even[idx] : 8'h00};
         @(posedge clk);
         #1 check((op == 2'b10 && ecsv != 2'b00) ? "R8 read merge" : {tag, " R8 read hold"},
                  32'(rdata), 32'(exp_rd));
      end

      // R5: upper byte read after idle cycles keeps lower lane zero
      @(negedge clk);
      addr = 20'h00031; hen = 1'b0; rd = 1'b1; wr = 1'b0;
      @(posedge clk);
      #1 check("R5 upper lane read", 32'(rdata), 32'h0000AB00);

      // R9: asynchronous reset between edges clears read data
      @(negedge clk);
      rd = 1'b0; hen = 1'b1; addr = 20'h00001;
      rst_n = 1'b0;
      #2 check("R9 async reset", 32'(rdata), 32'h0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 check("R9 idle after reset", 32'(rdata), 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule